// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog for a system bus. Software programs a reload value, a prescaler and a divide ratio, then enables the counter. Each divided tick takes one off the count. When the count runs out, the block raises an interrupt, a reset request, or both, and then reloads from the reload register. Software keeps the system alive by writing a fresh value into the counter before that happens.

In windowed mode a refresh is only accepted once the count has fallen to or below a programmable minimum. A refresh that arrives too early is treated exactly like an expiry. A debug-acknowledge input can suppress both outputs while a debugger holds the processor. That masking is switched on by a control bit.

Registers are reached over a simple valid/write/address/data bus. Read data is registered and appears one cycle after the request.

Top module: `win_watchdog`

## Requirements
- R1: After reset, control and minimum-count read 0, reload data and counter read 0x8000, and irq_o and rst_req_o are low.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (reload data), 0x08 (counter), 0x0C (interrupt clear, reads 0) and 0x10 (minimum count). The control fields are: bit 0 reset enable, bit 2 interrupt enable, bits 4:3 divide select, bit 5 count enable, bits 15:8 prescaler, bit 16 debug mask, bit 20 window enable. Other control bits read 0. Reload and minimum keep only the low 16 bits. Read data appears in the cycle after the read request and holds otherwise.
- R3: With count enable set, the counter steps once every (prescaler+1)×D clocks, where divide select 0,1,2,3 gives D = 16, 32, 64, 128. With count enable clear, the counter holds its value.
- R4: A count of N expires on the N-th tick (0 or 1 expire on the first tick), and the counter then reloads from the reload register, so expiries repeat every N×(prescaler+1)×D clocks.
- R5: When interrupt enable is set, an expiry or a window fault sets irq_o. irq_o stays high until any write to offset 0x0C.
- R6: When reset enable is set, an expiry or a window fault pulses rst_req_o high for one cycle. When reset enable is clear, no pulse appears.
- R7: A counter write with window mode off, or with the current count at or below the minimum, loads the written value and restarts the prescaler and divider phase.
- R8: With window mode on, a counter write while the current count is strictly above the minimum discards the written value, reloads from the reload register, and raises irq_o and rst_req_o as enabled, in the cycle after the write.
- R9: While the debug mask bit is set and dbg_ack is high, an event sets no interrupt and sends no reset pulse. With the mask bit clear, dbg_ack has no effect.
- R10: The sequence control=0, counter=0x80, reload=0x80, control=0x2021 (reset enable, divide 16, prescaler 0x20, enabled) produces a reset pulse 128×33×16 clocks after the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dbg_ack | input | 1 | Debug acknowledge; can mask the outputs |
| irq_o | output | 1 | Level interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The window test writes the counter at exactly the minimum and then just above it. A design that compared with greater-or-equal, or that loaded the early value instead of reloading, would show the wrong count or a stray interrupt. Repeated refreshes spaced closer than one tick must leave the count untouched, which exposes a divider whose phase is not restarted by the write. Expiry periods are measured between consecutive reset pulses for two prescaler and divide settings, so an off-by-one in either stage or a wrong divide encoding changes the cycle count. Debug masking is tried with the mask bit both set and clear, to catch a design that drops events whenever dbg_ack is high, or one that ignores it altogether.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int PRE_W     = 8;
  localparam int DIV_SEL_W = 2;

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_RELOAD = 'h04;
  localparam int OFF_COUNT  = 'h08;
  localparam int OFF_CLEAR  = 'h0C;
  localparam int OFF_MIN    = 'h10;

  localparam int B_RSTEN = 0;
  localparam int B_INTEN = 2;
  localparam int B_DIV   = 3;
  localparam int B_EN    = 5;
  localparam int B_PRE   = 8;
  localparam int B_MASK  = 16;
  localparam int B_WIN   = 20;

  typedef struct packed {
    logic                 win;
    logic                 dbg_mask;
    logic [PRE_W-1:0]     presc;
    logic                 en;
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 int_en;
    logic                 rst_en;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.rst_en   = w[B_RSTEN];
    c.int_en   = w[B_INTEN];
    c.div_sel  = w[B_DIV +: DIV_SEL_W];
    c.en       = w[B_EN];
    c.presc    = w[B_PRE +: PRE_W];
    c.dbg_mask = w[B_MASK];
    c.win      = w[B_WIN];
    return c;
  endfunction

  function automatic logic [31:0] pack_ctrl(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[B_RSTEN]           = c.rst_en;
    w[B_INTEN]           = c.int_en;
    w[B_DIV +: DIV_SEL_W] = c.div_sel;
    w[B_EN]              = c.en;
    w[B_PRE +: PRE_W]    = c.presc;
    w[B_MASK]            = c.dbg_mask;
    w[B_WIN]             = c.win;
    return w;
  endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  min_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              clr_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);
  localparam logic [IDX_W-1:0] I_CTRL   = IDX_W'(OFF_CTRL >> 2);
  localparam logic [IDX_W-1:0] I_RELOAD = IDX_W'(OFF_RELOAD >> 2);
  localparam logic [IDX_W-1:0] I_COUNT  = IDX_W'(OFF_COUNT >> 2);
  localparam logic [IDX_W-1:0] I_CLEAR  = IDX_W'(OFF_CLEAR >> 2);
  localparam logic [IDX_W-1:0] I_MIN    = IDX_W'(OFF_MIN >> 2);

  logic [IDX_W-1:0] idx;
  logic             wr, rd;
  logic [1:0]       unused_lsb;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = bus_addr[1:0];
  assign wr         = bus_valid && bus_write;
  assign rd         = bus_valid && !bus_write;

  assign cnt_wr_o    = wr && (idx == I_COUNT);
  assign cnt_wdata_o = bus_wdata[CNT_W-1:0];
  assign clr_o       = wr && (idx == I_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o   <= '0;
      reload_o <= CNT_INIT;
      min_o    <= '0;
    end else if (wr) begin
      case (idx)
        I_CTRL:   ctrl_o   <= unpack_ctrl(32'(bus_wdata));
        I_RELOAD: reload_o <= bus_wdata[CNT_W-1:0];
        I_MIN:    min_o    <= bus_wdata[CNT_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      case (idx)
        I_CTRL:   bus_rdata <= DATA_W'(pack_ctrl(ctrl_o));
        I_RELOAD: bus_rdata <= DATA_W'(reload_o);
        I_COUNT:  bus_rdata <= DATA_W'(cnt_val);
        I_MIN:    bus_rdata <= DATA_W'(min_o);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata)); // R2
endmodule

// File: rtl/wdg_tick.sv
module wdg_tick
  import wdg_pkg::*;
#(
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 restart_i,
  input  logic [PRE_W-1:0]     presc_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 tick_o
);
  localparam int DIV_W = DIV_BASE_LOG2 + (1 << DIV_SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_lim;
  logic [DIV_W:0]   div_full;

  always_comb begin
    div_full = (DIV_W + 1)'(1) << (DIV_BASE_LOG2 + int'(div_sel_i));
    div_lim  = DIV_W'(div_full - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i || restart_i) begin
      pre_q  <= '0;
      div_q  <= '0;
      tick_o <= 1'b0;
    end else if (pre_q == presc_i) begin
      pre_q <= '0;
      if (div_q == div_lim) begin
        div_q  <= '0;
        tick_o <= 1'b1;
      end else begin
        div_q  <= div_q + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      pre_q  <= pre_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(en_i)); // R3
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o); // R3
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic             win_i,
  input  logic             int_en_i,
  input  logic             rst_en_i,
  input  logic             mask_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             rst_o
);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

  logic expire, fault, fire;

  assign expire = en_i && tick_i && !wr_i && (cnt_o <= CNT_W'(1));
  assign fault  = wr_i && win_i && (cnt_o > min_i);
  assign fire   = (expire || fault) && !mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= CNT_INIT;
    end else if (wr_i) begin
      cnt_o <= fault ? reload_i : wdata_i;
    end else if (expire) begin
      cnt_o <= reload_i;
    end else if (en_i && tick_i) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      rst_o <= 1'b0;
    end else begin
      rst_o <= fire && rst_en_i;
      if (fire && int_en_i) irq_o <= 1'b1;
      else if (clr_i)       irq_o <= 1'b0;
    end
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt_o == $past(reload_i)); // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(fire && int_en_i)) |=> !irq_o); // R5
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    rst_o |-> $past(rst_en_i)); // R6
  AST_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !(win_i && cnt_o > min_i)) |=> cnt_o == $past(wdata_i)); // R7
  AST_WIN_FAULT: assert property (@(posedge clk) disable iff (rst)
    (wr_i && win_i && cnt_o > min_i && int_en_i && !mask_i) |=> irq_o); // R8
  AST_MASKED: assert property (@(posedge clk) disable iff (rst)
    (rst_o || $rose(irq_o)) |-> !$past(mask_i)); // R9
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 32,
  parameter int CNT_W         = 16,
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_ack,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, min_cnt, cnt_val, cnt_wdata;
  logic             cnt_wr, clr, tick, mask_act;

  assign mask_act = ctrl.dbg_mask && dbg_ack;

  wdg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt_val), .ctrl_o(ctrl), .reload_o(reload), .min_o(min_cnt),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata), .clr_o(clr)
  );

  wdg_tick #(.DIV_BASE_LOG2(DIV_BASE_LOG2)) u_tick (
    .clk(clk), .rst(rst), .en_i(ctrl.en), .restart_i(cnt_wr),
    .presc_i(ctrl.presc), .div_sel_i(ctrl.div_sel), .tick_o(tick)
  );

  wdg_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .en_i(ctrl.en), .tick_i(tick),
    .wr_i(cnt_wr), .wdata_i(cnt_wdata), .reload_i(reload), .min_i(min_cnt),
    .win_i(ctrl.win), .int_en_i(ctrl.int_en), .rst_en_i(ctrl.rst_en),
    .mask_i(mask_act), .clr_i(clr),
    .cnt_o(cnt_val), .irq_o(irq_o), .rst_o(rst_req_o)
  );

  AST_MASK_TOP: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> !$past(ctrl.dbg_mask && dbg_ack)); // R9
endmodule

// File: tb/win_watchdog_test.sv
module win_watchdog_test;
  localparam logic [31:0] RSTEN = 32'h1;
  localparam logic [31:0] INTEN = 32'h4;
  localparam logic [31:0] EN    = 32'h20;
  localparam logic [31:0] MASK  = 32'h1_0000;
  localparam logic [31:0] WIN   = 32'h10_0000;
  localparam logic [4:0] A_CTRL = 5'h00, A_REL = 5'h04, A_CNT = 5'h08,
                         A_CLR = 5'h0C, A_MIN = 5'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0, dbg_ack = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, rst_req_o;
  logic rst_seen;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  win_watchdog uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_ack(dbg_ack), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    rst_seen = rst_req_o;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_REL, d);  chk("R1 reload", d, 32'h8000);
    rd(A_CNT, d);  chk("R1 count", d, 32'h8000);
    rd(A_MIN, d);  chk("R1 min", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rst_req", rst_req_o, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); chk("R2 ctrl fields", d, 32'h0011_FF3D);
    wr(A_CTRL, 0);
    rd(A_CLR, d);  chk("R2 clear reads 0", d, 0);
    wr(A_REL, 32'hFFFF_ABCD);
    rd(A_REL, d);  chk("R2 reload width", d, 32'h0000_ABCD);
    wr(A_MIN, 32'h0000_1234);
    rd(A_MIN, d);  chk("R2 min", d, 32'h1234);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    wr(A_CTRL, 0);
    wr(A_CNT, 32'h1234);
    repeat (100) @(negedge clk);
    rd(A_CNT, d); chk("R3 disabled holds", d, 32'h1234);
  endtask

  task automatic t_phase();
    logic [31:0] d;
    wr(A_REL, 32'h40);
    wr(A_CTRL, EN);
    for (int i = 0; i < 8; i++) begin
      wr(A_CNT, 32'h5);
      repeat (8) @(negedge clk);
    end
    wr(A_CNT, 32'h5);
    rd(A_CNT, d); chk("R7 refresh restarts phase", d, 32'h5);
    repeat (20) @(negedge clk);
    rd(A_CNT, d); chk("R3 one tick step", d, 32'h4);
  endtask

  task automatic t_period(input int p, input int sel, input int n);
    int cyc, guard;
    int exp;
    exp = n * (p + 1) * (16 << sel);
    wr(A_CTRL, 0);
    wr(A_REL, n);
    wr(A_CNT, n);
    wr(A_CTRL, EN | RSTEN | (32'(sel) << 3) | (32'(p) << 8));
    guard = 0;
    do begin @(negedge clk); guard++; end while (!rst_req_o && guard < 5000);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rst_req_o && cyc < 5000);
    chk("R4 expiry period", cyc, exp);
  endtask

  task automatic t_irq();
    int guard;
    wr(A_CTRL, 0);
    wr(A_CLR, 0);
    wr(A_REL, 2);
    wr(A_CNT, 2);
    wr(A_CTRL, EN | INTEN);
    guard = 0;
    do begin @(negedge clk); guard++; chk("R6 no pulse when disabled", rst_req_o, 0); end
      while (!irq_o && guard < 200);
    chk("R5 irq raised", irq_o, 1);
    wr(A_CTRL, INTEN);
    repeat (50) @(negedge clk);
    chk("R5 irq held", irq_o, 1);
    wr(A_CLR, 0);
    chk("R5 irq cleared", irq_o, 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(A_CTRL, INTEN | RSTEN);
    wr(A_CLR, 0);
    wr(A_REL, 32'h77);
    wr(A_CNT, 32'h10);
    wr(A_MIN, 32'h10);
    wr(A_CTRL, INTEN | RSTEN | WIN);
    wr(A_CNT, 32'h50);
    chk("R8 equal to min allowed, no rst", rst_seen, 0);
    chk("R8 equal to min allowed, no irq", irq_o, 0);
    rd(A_CNT, d); chk("R7 loaded", d, 32'h50);
    wr(A_CNT, 32'h60);
    chk("R8 early refresh rst pulse", rst_seen, 1);
    chk("R8 early refresh irq", irq_o, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", rst_req_o, 0);
    rd(A_CNT, d); chk("R8 reloaded not written", d, 32'h77);
  endtask

  task automatic t_mask();
    wr(A_CLR, 0);
    wr(A_CTRL, INTEN | RSTEN | WIN | MASK);
    dbg_ack = 1'b1;
    wr(A_CNT, 32'h20);
    chk("R9 masked rst", rst_seen, 0);
    chk("R9 masked irq", irq_o, 0);
    dbg_ack = 1'b0;
    wr(A_CNT, 32'h20);
    chk("R9 unmasked rst", rst_seen, 1);
    chk("R9 unmasked irq", irq_o, 1);
    wr(A_CLR, 0);
    wr(A_CTRL, INTEN | RSTEN | WIN);
    dbg_ack = 1'b1;
    wr(A_CNT, 32'h20);
    chk("R9 mask bit clear ignores dbg_ack", irq_o, 1);
    dbg_ack = 1'b0;
  endtask

  task automatic t_restart();
    int cyc;
    wr(A_CTRL, 0);
    wr(A_CLR, 0);
    wr(A_CNT, 32'h80);
    wr(A_REL, 32'h80);
    wr(A_CTRL, 32'h2021);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!rst_req_o && cyc < 70000);
    chk("R10 restart reset timing", 32'((cyc >= 67580) && (cyc <= 67590)), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_hold();
    t_phase();
    t_period(1, 2, 2);
    t_period(0, 0, 3);
    t_period(2, 3, 1);
    t_irq();
    t_window();
    t_mask();
    t_restart();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule